// File: doc/BRIEF.md
# UART Banner Sequencer

This block feeds a fixed 27-byte text banner, one byte at a time, to a byte-wide serial transmitter that sits next to it. The banner is held in a constant on-chip table. Nothing is sent until a one-cycle trigger pulse arrives while the block is idle. The block then offers the first byte together with a one-cycle start strobe. It waits for the transmitter's done pulse, which marks that the byte has fully left the line, and only then offers the next byte.

The transmitter owns all serial bit timing. The sequencer owns the table, the byte index and the handshake. When the done pulse for the final byte arrives, the block returns to idle and raises a one-cycle message-complete pulse. A trigger that arrives while a banner is being sent has no effect. Every new banner starts again from the first byte.

Top module: `uart_banner_seq`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, and in the cycle after, `tx_start_o` and `msg_done_o` are low. After reset the block is idle at index 0, and it issues no strobe until a trigger is seen.
- R2: A trigger sampled high while idle makes `tx_start_o` high in the very next cycle, with `tx_data_o` equal to 0x0A (the byte at index 0).
- R3: `tx_start_o` is never high for two cycles in a row.
- R4: `tx_data_o` holds its value from the strobe cycle until the clock edge at which done is sampled.
- R5: After a strobe, no further strobe appears until `tx_done_i` has been sampled high. When done is sampled high for any byte except the last, the strobe for the next byte appears in the following cycle.
- R6: One banner is exactly 27 strobes. Their bytes are, in order: 0x0A, 0x0D, "LINK01", 0x20, "STRING/TX", 0x20, "TEST", 0x21, 0x0A, 0x0A, 0x0D. The byte at index 8 and the byte at index 18 are spaces, and the byte at index 23 is '!'.
- R7: The cycle after done is sampled for index 26, `msg_done_o` is high for exactly one cycle, no strobe follows, and the block is idle.
- R8: A trigger sampled while a banner is in progress is ignored. The banner continues unchanged and no extra bytes are sent.
- R9: A done pulse sampled while the block is idle produces no strobe and no completion pulse.
- R10: A trigger sampled in the cycle where `msg_done_o` is high starts a new banner from index 0.
- R11: A reset in the middle of a banner abandons it. No completion pulse is given for it, and the next trigger starts again at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trigger_i | input | 1 | Single-cycle request to send the banner |
| tx_done_i | input | 1 | Transmitter reports the current byte has left the line |
| tx_start_o | output | 1 | One-cycle strobe: `tx_data_o` is valid, start sending it |
| tx_data_o | output | 8 | Byte offered to the transmitter |
| msg_done_o | output | 1 | One-cycle pulse after the last byte's done |

## Verification
The hardest situations to reach are a reset that lands while the transmitter model is partway through a byte, and triggers that land while a banner is in flight, including on the same edge as a done pulse. The transmitter model answers each strobe after a random delay of 1 to 20 cycles. It drops out cleanly when reset appears, so the bench can abandon a banner at an arbitrary byte and then expect a fresh one from index 0. Extra trigger pulses are fired at fixed spacings during a banner, so some of them collide with done edges. Any restart or extra byte shows up as a mismatch in the scoreboard queue.

// File: rtl/ubs_pkg.sv
package ubs_pkg;

   localparam int unsigned BANNER_LEN = 27;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } ubs_state_e;

   // Constant banner text, one byte per index.
   function automatic logic [7:0] banner_byte(input int unsigned i);
      logic [7:0] b;
      case (i)
         0:  b = 8'h0A;
         1:  b = 8'h0D;
         2:  b = 8'h4C; // L
         3:  b = 8'h49; // I
         4:  b = 8'h4E; // N
         5:  b = 8'h4B; // K
         6:  b = 8'h30; // 0
         7:  b = 8'h31; // 1
         8:  b = 8'h20;
         9:  b = 8'h53; // S
         10: b = 8'h54; // T
         11: b = 8'h52; // R
         12: b = 8'h49; // I
         13: b = 8'h4E; // N
         14: b = 8'h47; // G
         15: b = 8'h2F; // /
         16: b = 8'h54; // T
         17: b = 8'h58; // X
         18: b = 8'h20;
         19: b = 8'h54; // T
         20: b = 8'h45; // E
         21: b = 8'h53; // S
         22: b = 8'h54; // T
         23: b = 8'h21; // !
         24: b = 8'h0A;
         25: b = 8'h0A;
         26: b = 8'h0D;
         default: b = 8'h00;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/ubs_rom.sv
module ubs_rom #(
   parameter int unsigned MSG_LEN = 27,
   parameter int unsigned DATA_W  = 8,
   localparam int unsigned IDX_W  = (MSG_LEN > 1) ? $clog2(MSG_LEN) : 1
) (
   input  logic [IDX_W-1:0]  addr_i,
   output logic [DATA_W-1:0] byte_o
);
   import ubs_pkg::*;

   logic [DATA_W-1:0] table_q [MSG_LEN];

   for (genvar gi = 0; gi < MSG_LEN; gi++) begin : g_entry
      assign table_q[gi] = DATA_W'(banner_byte(gi));
   end

   always_comb begin
      byte_o = '0;
      if (32'(addr_i) < MSG_LEN) byte_o = table_q[addr_i];
   end

endmodule

// File: rtl/ubs_index.sv
module ubs_index #(
   parameter int unsigned MSG_LEN = 27,
   localparam int unsigned IDX_W  = (MSG_LEN > 1) ? $clog2(MSG_LEN) : 1,
   localparam int unsigned LAST   = MSG_LEN - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr_i,
   input  logic             adv_i,
   output logic [IDX_W-1:0] idx_o,
   output logic [IDX_W-1:0] idx_nxt_o,
   output logic             last_o
);
   logic [IDX_W-1:0] idx_q = '0;

   always_ff @(posedge clk) begin
      if (rst)        idx_q <= '0;
      else if (clr_i) idx_q <= '0;
      else if (adv_i) idx_q <= idx_nxt_o;
   end

   assign idx_o     = idx_q;
   assign idx_nxt_o = idx_q + 1'b1;
   assign last_o    = (idx_q == IDX_W'(LAST));

   // The index never walks past the final table entry.
   assert_idx_in_range_R6: assert property (@(posedge clk) disable iff (rst)
      32'(idx_q) <= LAST);

   // Advancing from the last entry would leave the table.
   assert_no_adv_at_last_R7: assert property (@(posedge clk) disable iff (rst)
      adv_i |-> !last_o);

endmodule

// File: rtl/ubs_ctrl.sv
module ubs_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic trigger_i,
   input  logic done_i,
   input  logic last_i,
   output logic clr_o,
   output logic adv_o,
   output logic load_o,
   output logic sel_next_o,
   output logic strobe_o,
   output logic cmpl_o
);
   import ubs_pkg::*;

   ubs_state_e st_q     = ST_IDLE;
   logic       strobe_q = 1'b0;
   logic       cmpl_q   = 1'b0;

   logic start_msg, next_byte, finish_msg;

   always_comb begin
      start_msg  = (st_q == ST_IDLE) && trigger_i;
      next_byte  = (st_q == ST_WAIT) && done_i && !last_i;
      finish_msg = (st_q == ST_WAIT) && done_i && last_i;
   end

   assign clr_o      = start_msg || finish_msg;
   assign adv_o      = next_byte;
   assign load_o     = start_msg || next_byte;
   assign sel_next_o = next_byte;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q     <= ST_IDLE;
         strobe_q <= 1'b0;
         cmpl_q   <= 1'b0;
      end else begin
         strobe_q <= start_msg || next_byte;
         cmpl_q   <= finish_msg;
         case (st_q)
            ST_IDLE: if (start_msg)  st_q <= ST_WAIT;
            ST_WAIT: if (finish_msg) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign strobe_o = strobe_q;
   assign cmpl_o   = cmpl_q;

   assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
      strobe_q |=> !strobe_q);

   assert_wait_holds_R5: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_WAIT && !done_i) |=> !strobe_q);

   assert_trigger_ignored_R8: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_WAIT && trigger_i && !done_i) |=> (st_q == ST_WAIT));

   assert_cmpl_single_R7: assert property (@(posedge clk) disable iff (rst)
      cmpl_q |=> !cmpl_q);

   assert_cmpl_idle_R7: assert property (@(posedge clk) disable iff (rst)
      cmpl_q |-> (st_q == ST_IDLE) && !strobe_q);

   assert_idle_done_R9: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_IDLE && !trigger_i) |=> !strobe_q && !cmpl_q);

endmodule

// File: rtl/uart_banner_seq.sv
module uart_banner_seq #(
   parameter int unsigned MSG_LEN = 27,
   parameter int unsigned DATA_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              trigger_i,
   input  logic              tx_done_i,
   output logic              tx_start_o,
   output logic [DATA_W-1:0] tx_data_o,
   output logic              msg_done_o
);
   import ubs_pkg::*;

   localparam int unsigned IDX_W = (MSG_LEN > 1) ? $clog2(MSG_LEN) : 1;

   if (DATA_W != 8) begin : g_bad_width
      $error("uart_banner_seq: DATA_W must be 8");
   end
   if (MSG_LEN < 2 || MSG_LEN > BANNER_LEN) begin : g_bad_len
      $error("uart_banner_seq: MSG_LEN out of range");
   end

   logic             clr, adv, load, sel_next, last;
   logic [IDX_W-1:0] idx, idx_nxt, rom_addr;
   logic [DATA_W-1:0] rom_byte;
   logic [DATA_W-1:0] data_q = '0;

   ubs_ctrl u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .trigger_i  (trigger_i),
      .done_i     (tx_done_i),
      .last_i     (last),
      .clr_o      (clr),
      .adv_o      (adv),
      .load_o     (load),
      .sel_next_o (sel_next),
      .strobe_o   (tx_start_o),
      .cmpl_o     (msg_done_o)
   );

   ubs_index #(.MSG_LEN(MSG_LEN)) u_index (
      .clk       (clk),
      .rst       (rst),
      .clr_i     (clr),
      .adv_i     (adv),
      .idx_o     (idx),
      .idx_nxt_o (idx_nxt),
      .last_o    (last)
   );

   assign rom_addr = sel_next ? idx_nxt : '0;

   ubs_rom #(.MSG_LEN(MSG_LEN), .DATA_W(DATA_W)) u_rom (
      .addr_i (rom_addr),
      .byte_o (rom_byte)
   );

   always_ff @(posedge clk) begin
      if (rst)       data_q <= '0;
      else if (load) data_q <= rom_byte;
   end

   assign tx_data_o = data_q;

   // A strobe always comes with the byte at the current index.
   assert_strobe_byte_R6: assert property (@(posedge clk) disable iff (rst)
      tx_start_o |-> (tx_data_o == DATA_W'(banner_byte(32'(idx)))));

   assert_data_held_R4: assert property (@(posedge clk) disable iff (rst)
      (!tx_start_o && !tx_done_i && !trigger_i) |=> $stable(tx_data_o));

   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> !tx_start_o && !msg_done_o);

endmodule

// File: tb/uart_banner_seq_tb.sv
module uart_banner_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NBYTES     = 27;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       trigger_i = 1'b0;
   logic       done_model = 1'b0;
   logic       done_force = 1'b0;
   logic       tx_done_i;
   logic       tx_start_o;
   logic [7:0] tx_data_o;
   logic       msg_done_o;

   int checks = 0;
   int errors = 0;
   int strobes = 0;
   int completions = 0;
   logic [7:0] exp_q [$];

   string banner = "\n\rLINK01 STRING/TX TEST!\n\n\r";

   assign tx_done_i = done_model | done_force;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_banner_seq u_dut (
      .clk        (clk),
      .rst        (rst),
      .trigger_i  (trigger_i),
      .tx_done_i  (tx_done_i),
      .tx_start_o (tx_start_o),
      .tx_data_o  (tx_data_o),
      .msg_done_o (msg_done_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Driver: pulse trigger and push the expected banner into the scoreboard.
   task automatic start_message();
      for (int i = 0; i < NBYTES; i++) exp_q.push_back(banner[i]);
      trigger_i = 1'b1;
      @(negedge clk);
      trigger_i = 1'b0;
      check(tx_start_o == 1'b1, "R2", "strobe after trigger", tx_start_o, 1);
      check(tx_data_o == 8'h0A, "R2", "first byte", tx_data_o, 8'h0A);
   endtask

   // Transmitter model and scoreboard monitor.
   task automatic serve_byte();
      logic [7:0] held;
      logic [7:0] exp;
      int dly;
      bit gone;
      strobes++;
      held = tx_data_o;
      if (exp_q.size() == 0) begin
         check(1'b0, "R8", "unexpected strobe", held, 0);
      end else begin
         exp = exp_q.pop_front();
         check(held == exp, "R6", "byte value", held, exp);
      end
      dly = 1 + int'($urandom % 20);
      gone = 1'b0;
      for (int k = 0; k < dly; k++) begin
         @(negedge clk);
         if (rst) begin
            gone = 1'b1;
            break;
         end
         if (k == 0) check(!tx_start_o, "R3", "strobe width", tx_start_o, 0);
         else        check(!tx_start_o, "R5", "strobe before done", tx_start_o, 0);
         check(tx_data_o == held, "R4", "data held", tx_data_o, held);
      end
      if (gone) return;
      done_model = 1'b1;
      @(negedge clk);
      done_model = 1'b0;
      if (rst) return;
      if (exp_q.size() == 0) begin
         check(msg_done_o == 1'b1, "R7", "completion pulse", msg_done_o, 1);
         check(!tx_start_o, "R7", "no strobe after last", tx_start_o, 0);
      end else begin
         check(tx_start_o == 1'b1, "R5", "next strobe after done", tx_start_o, 1);
      end
   endtask

   initial begin
      forever begin
         @(negedge clk);
         while (!rst && tx_start_o) serve_byte();
      end
   end

   always @(negedge clk) if (!rst && msg_done_o) completions++;

   task automatic wait_complete(input string req);
      int n;
      n = 0;
      while (!msg_done_o && n < 3000) begin
         @(negedge clk);
         n++;
      end
      check(msg_done_o == 1'b1, req, "banner completed", msg_done_o, 1);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(!tx_start_o, "R1", "strobe in reset", tx_start_o, 0);
      check(!msg_done_o, "R1", "done in reset", msg_done_o, 0);
      rst = 1'b0;
      repeat (10) @(negedge clk);
      check(strobes == 0, "R1", "no strobe without trigger", strobes, 0);

      // R9: done while idle
      done_force = 1'b1;
      repeat (3) @(negedge clk);
      done_force = 1'b0;
      repeat (3) @(negedge clk);
      check(strobes == 0, "R9", "idle done strobe", strobes, 0);
      check(completions == 0, "R9", "idle done completion", completions, 0);

      // First banner
      start_message();
      wait_complete("R7");
      @(negedge clk);
      check(!msg_done_o, "R7", "completion one cycle", msg_done_o, 0);
      check(strobes == NBYTES, "R6", "strobes per banner", strobes, NBYTES);

      // R8: triggers while busy
      repeat (5) @(negedge clk);
      start_message();
      for (int p = 0; p < 6; p++) begin
         repeat (37) @(negedge clk);
         trigger_i = 1'b1;
         @(negedge clk);
         trigger_i = 1'b0;
      end
      wait_complete("R8");

      // R10: trigger in the completion cycle
      start_message();
      check(strobes == 2*NBYTES + 1, "R10", "restart at index 0", strobes, 2*NBYTES + 1);
      wait_complete("R10");

      // R11: reset mid-banner
      @(negedge clk);
      start_message();
      while (strobes < 3*NBYTES + 12) @(negedge clk);
      repeat (3) @(negedge clk);
      rst = 1'b1;
      exp_q.delete();
      repeat (2) @(negedge clk);
      check(!tx_start_o, "R11", "strobe in reset", tx_start_o, 0);
      rst = 1'b0;
      repeat (8) @(negedge clk);
      check(completions == 3, "R11", "no completion for abandoned banner", completions, 3);
      start_message();
      wait_complete("R11");
      repeat (5) @(negedge clk);

      check(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
      check(completions == 4, "R7", "completion count", completions, 4);
      finish_run();
   end

endmodule